// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This block moves outgoing frames from memory to a transmit MAC. Software builds a linked chain of three-word descriptors, each word 32 bits wide and each descriptor naming a buffer, a count word and a link to the following descriptor. Software loads the first descriptor's address into the next-pointer register and then writes the status register with the active bit set. The engine reads each descriptor and streams its buffer out byte by byte. It waits for the MAC's verdict on that frame and writes the count word back with the done flag set. It then follows the link, or halts when the descriptor carries the end-of-ring mark. To extend a running chain, software clears end-of-ring and interrupt-on-completion on the old tail.

The controller is a single state machine with these states:
- `S_IDLE` waits for a start.
- `S_DESC_A`, `S_DESC_C` and `S_DESC_N` issue the reads of descriptor words 0, 1 and 2 back to back.
- `S_CHECK` takes in the link word and decides what to do with the descriptor. It goes to `S_IDLE` when the descriptor is not owned, to `S_WB` when the length is zero, and to `S_LOAD` otherwise.
- `S_LOAD` reads a buffer word.
- `S_CAP` captures that word.
- `S_SEND` offers bytes. It goes to `S_LOAD` at a word boundary and to `S_RESULT` after the final byte.
- `S_RESULT` waits for the MAC verdict.
- `S_WB` writes the count word back. It goes to `S_IDLE` on an error or end-of-ring, and to `S_DESC_A` otherwise.

Memory is word addressed. Read data is valid the cycle after a read request, and writes take effect at the clock edge of the request.

Top module: `txd_chain_dma`

## Requirements
- R1: After reset the status register reads 0, both pointer registers read 0, `irq` is low and no memory or byte-stream request is made.
- R2: A register write to address 2 with bit 9 set, while the engine is halted, copies the next-pointer register (address 1) into the current-pointer register (address 0) and sets status bit 9. The engine then reads the descriptor words at pointer+0 (buffer byte address), pointer+1 (count word) and pointer+2 (link pointer).
- R3: Buffer bytes go out in ascending byte-address order. The byte at address A is taken from word A>>2, lane A[1:0], with lane 0 at bits 7:0. `tx_last` marks the final byte. `tx_data` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low.
- R4: The byte count is count-word bits 13:0. Counts above MAX_FRAME (default 1518) send exactly MAX_FRAME bytes.
- R5: After the MAC result, the engine writes the count word back to pointer+1 with bit 15 (done) set. All other bits keep the value that was read.
- R6: When count-word bit 31 (end-of-ring) is clear and the frame did not fail, the engine loads the link pointer into the current-pointer register and processes that descriptor next.
- R7: When bit 31 is set, the engine halts after the write-back and status bit 9 clears.
- R8: `irq` pulses high for exactly one cycle, the cycle after the write-back, when count-word bit 29 was set or the frame failed.
- R9: Result codes are 0 ok, 1 collision, 2 too many retries and 3 underflow. Each result sets status bit 3, 1, 2 or 0 respectively and clears the other three of those bits.
- R10: A result of too many retries or underflow halts the engine after the write-back, even without end-of-ring.
- R11: A descriptor whose bit 24 (busy) is clear halts the engine at once. No bytes are sent, no write-back occurs and status bit 9 clears.
- R12: A busy descriptor with byte count 0 is written back with done set. No bytes are sent and status bits 3:0 are unchanged.
- R13: A status read (`reg_rd` with address 2) sets status bit 7 from the next cycle. Any later start, halt or result clears it.
- R14: While the engine is active, writes to either pointer register and start requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status side effect) |
| reg_addr | input | 2 | 0 current pointer, 1 next pointer, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| tx_valid | output | 1 | Byte offered to the MAC |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte |
| res_valid | input | 1 | MAC frame result strobe |
| res_code | input | 2 | MAC frame result code |
| irq | output | 1 | Completion interrupt pulse |

## Verification
- **Bytes.** Each byte leaves in the cycle whose `tx_valid`/`tx_ready` handshake the bench sees at the falling edge. The scoreboard compares it against the head of the expected queue at that edge.
- **MAC verdict and status.** The bench returns the verdict two falling edges after the last byte, while the engine waits in `S_RESULT`. The result bits then appear at the next rising edge. The write-back follows one cycle later, and `irq` and the halt take effect at the edge after that.
- **Register checks.** Status and pointer values are read only after status bit 9 is seen low. Status bit 9 is read without the read strobe.
- **Ignored stimulus.** Pointer writes and restarts issued during a run are checked through the current-pointer value once the engine halts. Unowned descriptors are checked through the untouched count word in memory.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 14;

    // count word fields
    localparam int CW_EOR  = 31;
    localparam int CW_EOP  = 30;
    localparam int CW_IOC  = 29;
    localparam int CW_BUSY = 24;
    localparam int CW_DONE = 15;

    // status register fields
    localparam int ST_ACTIVE = 9;
    localparam int ST_READ   = 7;
    localparam int ST_OK     = 3;
    localparam int ST_MAXTRY = 2;
    localparam int ST_COLL   = 1;
    localparam int ST_UNDER  = 0;

    typedef enum logic [3:0] {
        S_IDLE, S_DESC_A, S_DESC_C, S_DESC_N, S_CHECK,
        S_LOAD, S_CAP, S_SEND, S_RESULT, S_WB
    } txd_state_e;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_COLL   = 2'd1,
        RES_MAXTRY = 2'd2,
        RES_UNDER  = 2'd3
    } txd_res_e;
endpackage

// File: rtl/txd_lane_sel.sv
module txd_lane_sel #(
    parameter int LANES = 4,
    localparam int SW   = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] word_i,
    input  logic [SW-1:0]      sel_i,
    output logic [7:0]         byte_o
);
    logic [7:0] lane_w [LANES];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_w[g] = word_i[8*g +: 8];
        end
    endgenerate

    assign byte_o = lane_w[sel_i];
endmodule

// File: rtl/txd_status.sv
module txd_status
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              res_upd_i,
    input  logic [1:0]        res_code_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] status_o
);
    logic       active_q;
    logic       read_q;
    logic [3:0] res_q;
    logic [3:0] res_onehot;

    always_comb begin
        res_onehot = '0;
        unique case (txd_res_e'(res_code_i))
            RES_OK:     res_onehot[ST_OK]     = 1'b1;
            RES_COLL:   res_onehot[ST_COLL]   = 1'b1;
            RES_MAXTRY: res_onehot[ST_MAXTRY] = 1'b1;
            RES_UNDER:  res_onehot[ST_UNDER]  = 1'b1;
            default:    res_onehot = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            read_q   <= 1'b0;
            res_q    <= '0;
        end else begin
            if (start_i)   active_q <= 1'b1;
            if (stop_i)    active_q <= 1'b0;
            if (res_upd_i) res_q    <= res_onehot;
            if (start_i || stop_i || res_upd_i) read_q <= 1'b0;
            else if (rd_i)                      read_q <= 1'b1;
        end
    end

    always_comb begin
        status_o            = '0;
        status_o[ST_ACTIVE] = active_q;
        status_o[ST_READ]   = read_q;
        status_o[3:0]       = res_q;
    end
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
    import txd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int MAX_FRAME = 1518,
    localparam int LW       = $clog2(DATA_W/8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req_i,
    input  logic              wr_cur_i,
    input  logic              wr_nxt_i,
    input  logic [AW-1:0]     ptr_wdata_i,
    output logic [AW-1:0]     cur_ptr_o,
    output logic [AW-1:0]     nxt_ptr_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_last_o,
    input  logic              tx_ready_i,
    input  logic              res_valid_i,
    input  logic [1:0]        res_code_i,
    output logic              start_o,
    output logic              stop_o,
    output logic              res_upd_o,
    output logic              irq_o
);
    txd_state_e state, state_d;

    logic [AW-1:0]     cur_q, nxt_q, nextp_q;
    logic [AW+LW-1:0]  buf_q;
    logic [DATA_W-1:0] cnt_q, data_q;
    logic [LEN_W-1:0]  remain_q, len_w, clamp_w;
    logic              err_q, irq_q, halt_w;

    assign len_w   = cnt_q[LEN_W-1:0];
    assign clamp_w = (len_w > LEN_W'(MAX_FRAME)) ? LEN_W'(MAX_FRAME) : len_w;
    assign halt_w  = err_q || cnt_q[CW_EOR];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:   if (start_req_i) state_d = S_DESC_A;
            S_DESC_A: state_d = S_DESC_C;
            S_DESC_C: state_d = S_DESC_N;
            S_DESC_N: state_d = S_CHECK;
            S_CHECK: begin
                if (!cnt_q[CW_BUSY])  state_d = S_IDLE;
                else if (len_w == '0) state_d = S_WB;
                else                  state_d = S_LOAD;
            end
            S_LOAD:   state_d = S_CAP;
            S_CAP:    state_d = S_SEND;
            S_SEND: begin
                if (tx_ready_i) begin
                    if (remain_q == LEN_W'(1))  state_d = S_RESULT;
                    else if (&buf_q[LW-1:0])    state_d = S_LOAD;
                end
            end
            S_RESULT: if (res_valid_i) state_d = S_WB;
            S_WB:     state_d = halt_w ? S_IDLE : S_DESC_A;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            nxt_q    <= '0;
            nextp_q  <= '0;
            buf_q    <= '0;
            cnt_q    <= '0;
            data_q   <= '0;
            remain_q <= '0;
            err_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start_req_i) cur_q <= nxt_q;
                    else begin
                        if (wr_cur_i) cur_q <= ptr_wdata_i;
                        if (wr_nxt_i) nxt_q <= ptr_wdata_i;
                    end
                end
                S_DESC_A: err_q <= 1'b0;
                S_DESC_C: buf_q <= mem_rdata_i[AW+LW-1:0];
                S_DESC_N: cnt_q <= mem_rdata_i;
                S_CHECK: begin
                    nextp_q  <= mem_rdata_i[AW-1:0];
                    nxt_q    <= mem_rdata_i[AW-1:0];
                    remain_q <= clamp_w;
                end
                S_CAP: data_q <= mem_rdata_i;
                S_SEND: begin
                    if (tx_ready_i) begin
                        buf_q    <= buf_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                    end
                end
                S_RESULT: begin
                    if (res_valid_i)
                        err_q <= (res_code_i == RES_MAXTRY) || (res_code_i == RES_UNDER);
                end
                S_WB: begin
                    irq_q <= cnt_q[CW_IOC] || err_q;
                    if (!halt_w) cur_q <= nextp_q;
                end
                default: ;
            endcase
        end
    end

    txd_lane_sel #(.LANES(DATA_W/8)) u_lane (
        .word_i (data_q),
        .sel_i  (buf_q[LW-1:0]),
        .byte_o (tx_data_o)
    );

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = cur_q;
        mem_wdata_o = cnt_q | (DATA_W'(1) << CW_DONE);
        tx_valid_o  = 1'b0;
        tx_last_o   = 1'b0;
        start_o     = 1'b0;
        stop_o      = 1'b0;
        res_upd_o   = 1'b0;
        unique case (state)
            S_IDLE:   start_o = start_req_i;
            S_DESC_A: mem_req_o = 1'b1;
            S_DESC_C: begin mem_req_o = 1'b1; mem_addr_o = cur_q + AW'(1); end
            S_DESC_N: begin mem_req_o = 1'b1; mem_addr_o = cur_q + AW'(2); end
            S_CHECK:  stop_o = !cnt_q[CW_BUSY];
            S_LOAD:   begin mem_req_o = 1'b1; mem_addr_o = buf_q[AW+LW-1:LW]; end
            S_SEND: begin
                tx_valid_o = 1'b1;
                tx_last_o  = (remain_q == LEN_W'(1));
            end
            S_RESULT: res_upd_o = res_valid_i;
            S_WB: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = cur_q + AW'(1);
                stop_o     = halt_w;
            end
            default: ;
        endcase
    end

    assign cur_ptr_o = cur_q;
    assign nxt_ptr_o = nxt_q;
    assign irq_o     = irq_q;
endmodule

// File: rtl/txd_chain_dma.sv
module txd_chain_dma
    import txd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int MAX_FRAME = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              res_valid,
    input  logic [1:0]        res_code,
    output logic              irq
);
    localparam logic [1:0] A_CUR = 2'd0, A_NXT = 2'd1, A_STAT = 2'd2;

    logic [AW-1:0]     cur_w, nxt_w;
    logic [DATA_W-1:0] status_w;
    logic              start_w, stop_w, res_upd_w;
    logic              start_req_w, wr_cur_w, wr_nxt_w, rd_stat_w;

    assign start_req_w = reg_wr && (reg_addr == A_STAT) && reg_wdata[ST_ACTIVE];
    assign wr_cur_w    = reg_wr && (reg_addr == A_CUR);
    assign wr_nxt_w    = reg_wr && (reg_addr == A_NXT);
    assign rd_stat_w   = reg_rd && (reg_addr == A_STAT);

    txd_ctrl #(.AW(AW), .MAX_FRAME(MAX_FRAME)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (start_req_w),
        .wr_cur_i    (wr_cur_w),
        .wr_nxt_i    (wr_nxt_w),
        .ptr_wdata_i (reg_wdata[AW-1:0]),
        .cur_ptr_o   (cur_w),
        .nxt_ptr_o   (nxt_w),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .tx_valid_o  (tx_valid),
        .tx_data_o   (tx_data),
        .tx_last_o   (tx_last),
        .tx_ready_i  (tx_ready),
        .res_valid_i (res_valid),
        .res_code_i  (res_code),
        .start_o     (start_w),
        .stop_o      (stop_w),
        .res_upd_o   (res_upd_w),
        .irq_o       (irq)
    );

    txd_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .res_upd_i  (res_upd_w),
        .res_code_i (res_code),
        .rd_i       (rd_stat_w),
        .status_o   (status_w)
    );

    always_comb begin
        unique case (reg_addr)
            A_CUR:   reg_rdata = DATA_W'(cur_w);
            A_NXT:   reg_rdata = DATA_W'(nxt_w);
            A_STAT:  reg_rdata = status_w;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/txd_chain_dma_chk.sv
module txd_chain_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        mem_req,
    input logic        mem_we,
    input logic        irq,
    input logic [31:0] status
);
    // R3: offered byte held until accepted
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R3: last marker only with a valid byte
    a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R5: writes are memory requests
    a_r5_we_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R8: interrupt is a single-cycle pulse
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: at most one result bit
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[3:0]));

    // R11: no bytes while halted
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !status[9] |-> !tx_valid);

    // R13: a start clears the read flag
    a_r13_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[9]) |-> !status[7]);
endmodule

bind txd_chain_dma txd_chain_dma_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .irq      (irq),
    .status   (status_w)
);

// File: tb/txd_chain_dma_test.sv
module txd_chain_dma_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam logic [31:0] EOR = 32'h8000_0000, EOP = 32'h4000_0000,
                            IOC = 32'h2000_0000, BUSY = 32'h0100_0000,
                            DONE = 32'h0000_8000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, rd_q = '0;
    logic        tx_valid, tx_last, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        res_valid = 1'b0;
    logic [1:0]  res_code = 2'd0;
    logic        irq;

    logic [31:0] m [1024];
    logic [8:0]  exp_q [$];
    logic [1:0]  res_q [$];
    int checks = 0, errors = 0, irq_cnt = 0, tick = 0, res_wait = 0;

    txd_chain_dma #(.AW(AW)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: read data one cycle after request
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) m[mem_addr[9:0]] <= mem_wdata;
            else        rd_q <= m[mem_addr[9:0]];
        end
    end
    assign mem_rdata = rd_q;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // MAC model and scoreboard monitor
    always @(negedge clk) begin
        tick++;
        tx_ready = ((tick % 5) != 2);
        res_valid = 1'b0;
        if (irq) irq_cnt++;
        if (res_wait > 0) begin
            res_wait--;
            if (res_wait == 0) begin
                res_valid = 1'b1;
                res_code  = (res_q.size() > 0) ? res_q.pop_front() : 2'd0;
            end
        end
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected byte", {24'd0, tx_data}, 32'd0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(tx_data == e[7:0], "R3 byte", {24'd0, tx_data}, {24'd0, e[7:0]});
                check(tx_last == e[8], "R3 last", {31'd0, tx_last}, {31'd0, e[8]});
                if (e[8]) res_wait = 2;
            end
        end
    end

    // driver: build a descriptor and push expected bytes/result
    task automatic mk_desc(input int d, input int bufb, input int len, input logic [31:0] flags,
                           input int nxt, input int seed, input bit sends, input logic [1:0] res);
        int n;
        m[d]   = bufb;
        m[d+1] = flags | len;
        m[d+2] = nxt;
        n = (len > 1518) ? 1518 : len;
        for (int i = 0; i < n; i++) begin
            int a;
            logic [7:0] v;
            a = bufb + i;
            v = 8'(seed + i * 3);
            m[a >> 2][8*(a & 3) +: 8] = v;
            if (sends) exp_q.push_back({(i == n - 1), v});
        end
        if (sends && n > 0) res_q.push_back(res);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            peek(2'd2, s);
            if (!s[9]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run(input int d);
        reg_write(2'd1, d);
        reg_write(2'd2, 32'h200);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, c;
        int ic;
        for (int i = 0; i < 1024; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(2'd2, v); check(v == 0, "R1 status", v, 0);
        peek(2'd0, v); check(v == 0, "R1 cur ptr", v, 0);
        check(!irq && !tx_valid && !mem_req, "R1 outputs idle", {irq, tx_valid, mem_req}, 0);

        // R2 R5 R7 R8 R9: single ok frame at end of ring
        mk_desc(32'h10, 32'h400, 9, BUSY | EOP | EOR | IOC, 32'h14, 5, 1, 2'd0);
        c = m[32'h11]; ic = irq_cnt;
        run(32'h10); wait_idle();
        peek(2'd2, v); check(v == 32'h8, "R7 R9 status after ok", v, 32'h8);
        check(m[32'h11] == (c | DONE), "R5 done writeback", m[32'h11], c | DONE);
        check(irq_cnt == ic + 1, "R8 irq on completion", irq_cnt, ic + 1);
        check(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
        peek(2'd0, v); check(v == 32'h10, "R2 cur loaded", v, 32'h10);

        // R6 R14: two-descriptor chain, unaligned buffers, ignored writes
        mk_desc(32'h20, 32'h503, 6, BUSY | EOP, 32'h24, 40, 1, 2'd1);
        mk_desc(32'h24, 32'h602, 5, BUSY | EOP | EOR | IOC, 32'h20, 90, 1, 2'd0);
        ic = irq_cnt;
        run(32'h20);
        reg_write(2'd0, 32'h3f0);
        reg_write(2'd1, 32'h3f0);
        reg_write(2'd2, 32'h200);
        wait_idle();
        peek(2'd0, v); check(v == 32'h24, "R6 R14 cur follows chain", v, 32'h24);
        check(m[32'h21][15] && m[32'h25][15], "R6 both done", {m[32'h21][15], m[32'h25][15]}, 2'b11);
        peek(2'd2, v); check(v == 32'h8, "R9 collision replaced by ok", v, 32'h8);
        check(irq_cnt == ic + 1, "R8 irq only on tail", irq_cnt, ic + 1);
        check(exp_q.size() == 0, "R3 chain bytes", exp_q.size(), 0);

        // R10 underflow stops chain
        mk_desc(32'h30, 32'h700, 4, BUSY | EOP, 32'h34, 17, 1, 2'd3);
        mk_desc(32'h34, 32'h740, 4, BUSY | EOP | EOR, 32'h30, 60, 0, 2'd0);
        c = m[32'h35]; ic = irq_cnt;
        run(32'h30); wait_idle();
        peek(2'd2, v); check(v == 32'h1, "R9 R10 underflow status", v, 32'h1);
        check(m[32'h35] == c, "R10 next descriptor untouched", m[32'h35], c);
        check(irq_cnt == ic + 1, "R8 irq on error", irq_cnt, ic + 1);
        peek(2'd0, v); check(v == 32'h30, "R10 cur stays", v, 32'h30);

        // R9 R10 too many retries
        mk_desc(32'h40, 32'h780, 3, BUSY | EOP | EOR, 32'h40, 200, 1, 2'd2);
        run(32'h40); wait_idle();
        peek(2'd2, v); check(v == 32'h4, "R9 maxtry status", v, 32'h4);

        // R11 not owned
        mk_desc(32'h48, 32'h7a0, 5, EOP | EOR | IOC, 32'h48, 1, 0, 2'd0);
        c = m[32'h49]; ic = irq_cnt;
        run(32'h48); wait_idle();
        peek(2'd2, v); check(v == 32'h4, "R11 halted status", v, 32'h4);
        check(m[32'h49] == c, "R11 no writeback", m[32'h49], c);
        check(irq_cnt == ic, "R11 no irq", irq_cnt, ic);

        // R12 zero length
        mk_desc(32'h50, 32'h7c0, 0, BUSY | EOP | EOR, 32'h50, 1, 0, 2'd0);
        c = m[32'h51];
        run(32'h50); wait_idle();
        check(m[32'h51] == (c | DONE), "R12 done on empty", m[32'h51], c | DONE);
        peek(2'd2, v); check(v == 32'h4, "R12 result bits kept", v, 32'h4);

        // R13 read flag
        reg_read(2'd2, v); check(v == 32'h4, "R13 read value", v, 32'h4);
        peek(2'd2, v); check(v == 32'h84, "R13 flag set", v, 32'h84);

        // R4 clamp, R13 cleared by new activity
        mk_desc(32'h58, 32'h800, 1600, BUSY | EOP | EOR, 32'h58, 77, 1, 2'd0);
        run(32'h58); wait_idle();
        check(exp_q.size() == 0, "R4 clamped length", exp_q.size(), 0);
        peek(2'd2, v); check(v == 32'h8, "R13 flag cleared", v, 32'h8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule